// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block gathers the eleven interrupt events of a UART into a raw status register. It holds a programmable enable mask and forms the masked status as the bitwise AND of the two. From the masked status it drives a single level interrupt line toward an interrupt controller. The UART datapath sends one-cycle set pulses, one bit per source. Software reaches the block through a small register port: it programs the mask, reads the raw and masked status, and clears events by writing ones.

When the masked status goes from empty to non-empty, the line rises `IRQ_DELAY + 1` cycles later, provided the masked status stays non-empty for that whole time. If the masked status empties again before then, the pending assertion is dropped and the line never pulses. Once high, the line falls in the same cycle that the masked status becomes empty.

The register port has no back-pressure. A write is taken in the cycle its strobe is high. Read data appears one cycle after the read strobe. The port has plain strobes only, with no valid/ready handshake. Source bit positions: 0 ring indicator, 1 clear-to-send change, 2 carrier-detect change, 3 data-set-ready change, 4 receive, 5 transmit, 6 receive timeout, 7 framing error, 8 parity error, 9 break, 10 overrun.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset the raw status and the mask are zero, `irq_o` is low, and every register reads zero.
- R2: A high bit on `src_set_i` sets the same bit of the raw status (read at offset 0x03C) from the next cycle on. Other raw bits keep their value.
- R3: Writing to offset 0x044 clears each raw bit whose write-data bit is 1 and leaves the other raw bits alone. A read of 0x044 returns zero.
- R4: Offset 0x038 holds the mask, which is read/write. A read of 0x040 returns raw AND mask. Writes to 0x03C and 0x040 have no effect.
- R5: When the masked status first becomes non-zero in cycle t and stays non-zero, `irq_o` rises in cycle t+1+IRQ_DELAY. With IRQ_DELAY = 0 it rises in cycle t+1.
- R6: `irq_o` is low in every cycle in which the masked status is zero. It therefore falls in the same cycle the masked status becomes zero.
- R7: If the masked status returns to zero before the delay expires, the pending assertion is cancelled, and `irq_o` never goes high for that event.
- R8: If a set pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R9: A mask write re-evaluates the current raw status under the same rules. Unmasking a pending source starts the delay, and masking every pending source drops `irq_o`.
- R10: Read data bits 15 to 11 are always zero, and mask write bits above bit 10 are discarded.
- R11: `rd_data_o` shows the addressed register in the cycle after `rd_en_i` and holds its value otherwise. An unmapped address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, synchronous |
| src_set_i | input | NUM_SRC | One-cycle set pulses from the UART datapath |
| addr_i | input | ADDR_W | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | DATA_W | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Level interrupt toward the controller |

## Verification
A set pulse from the datapath and a software clear of the same raw bit can land in the same cycle. The bench provokes this by driving `src_set_i` and a write to 0x044 together. It judges the result by reading the raw status back and by watching `irq_o` stay up. A mask write can also fall in the cycle the masked status would otherwise change. The bench covers this by unmasking a source that is already pending and then masking it away before the delay runs out. It judges that case by requiring `irq_o` to stay low on every cycle of the window.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ADDR_W_P = 12;

  localparam logic [ADDR_W_P-1:0] OFS_ENABLE = 12'h038;
  localparam logic [ADDR_W_P-1:0] OFS_RAW    = 12'h03C;
  localparam logic [ADDR_W_P-1:0] OFS_MASKED = 12'h040;
  localparam logic [ADDR_W_P-1:0] OFS_CLEAR  = 12'h044;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_RAW,
    SEL_MASKED
  } rd_sel_e;

  typedef enum int {
    SRC_RING    = 0,
    SRC_CTS     = 1,
    SRC_DCD     = 2,
    SRC_DSR     = 3,
    SRC_RX      = 4,
    SRC_TX      = 5,
    SRC_RXTO    = 6,
    SRC_FRAME   = 7,
    SRC_PARITY  = 8,
    SRC_BREAK   = 9,
    SRC_OVERRUN = 10
  } src_idx_e;
endpackage

// File: rtl/uart_irq_bus.sv
module uart_irq_bus
  import uart_irq_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               rd_en_i,
  input  logic [NUM_SRC-1:0] enable_q_i,
  input  logic [NUM_SRC-1:0] raw_q_i,
  output logic               enable_we_o,
  output logic               clear_we_o,
  output logic [NUM_SRC-1:0] wr_bits_o,
  output logic [DATA_W-1:0]  rd_data_o
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  rd_sel_e            sel;
  logic [NUM_SRC-1:0] rd_bits;
  logic [DATA_W-1:0]  rd_q;

  assign enable_we_o = wr_en_i && (addr_i == ADDR_W'(OFS_ENABLE));
  assign clear_we_o  = wr_en_i && (addr_i == ADDR_W'(OFS_CLEAR));
  assign wr_bits_o   = wr_data_i[NUM_SRC-1:0];

  always_comb begin
    if (addr_i == ADDR_W'(OFS_ENABLE))      sel = SEL_ENABLE;
    else if (addr_i == ADDR_W'(OFS_RAW))    sel = SEL_RAW;
    else if (addr_i == ADDR_W'(OFS_MASKED)) sel = SEL_MASKED;
    else                                    sel = SEL_NONE;
  end

  always_comb begin
    unique case (sel)
      SEL_ENABLE: rd_bits = enable_q_i;
      SEL_RAW:    rd_bits = raw_q_i;
      SEL_MASKED: rd_bits = raw_q_i & enable_q_i;
      default:    rd_bits = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= {{PAD_W{1'b0}}, rd_bits};
  end

  assign rd_data_o = rd_q;

  // R10
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:NUM_SRC] == '0);

  // R11
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs #(
  parameter int NUM_SRC = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_set_i,
  input  logic               enable_we_i,
  input  logic               clear_we_i,
  input  logic [NUM_SRC-1:0] wr_bits_i,
  output logic [NUM_SRC-1:0] enable_q_o,
  output logic [NUM_SRC-1:0] raw_q_o,
  output logic               any_o
);
  logic [NUM_SRC-1:0] clr_bits;

  assign clr_bits = clear_we_i ? wr_bits_i : '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        raw_q_o[i]    <= 1'b0;
        enable_q_o[i] <= 1'b0;
      end else begin
        if (src_set_i[i])      raw_q_o[i] <= 1'b1;
        else if (clr_bits[i])  raw_q_o[i] <= 1'b0;
        if (enable_we_i)       enable_q_o[i] <= wr_bits_i[i];
      end
    end
  end

  assign any_o = |(raw_q_o & enable_q_o);

  // R2, R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_set_i) |=> ((raw_q_o & $past(src_set_i)) == $past(src_set_i)));

  // R3
  clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_bits & ~src_set_i)) |=> ((raw_q_o & $past(clr_bits & ~src_set_i)) == '0));
endmodule

// File: rtl/uart_irq_delay.sv
module uart_irq_delay #(
  parameter int IRQ_DELAY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_i,
  output logic irq_o
);
  localparam int CNT_W = (IRQ_DELAY > 0) ? $clog2(IRQ_DELAY + 1) : 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IRQ_DELAY);

  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !any_i) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else if (!irq_q) begin
      if (cnt_q == LIMIT) irq_q <= 1'b1;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  assign irq_o = irq_q & any_i;

  // R5, R7
  rise_after_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(any_i));
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit #(
  parameter int NUM_SRC   = 11,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 12,
  parameter int IRQ_DELAY = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_set_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               rd_en_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_o
);
  logic               enable_we;
  logic               clear_we;
  logic [NUM_SRC-1:0] wr_bits;
  logic [NUM_SRC-1:0] enable_q;
  logic [NUM_SRC-1:0] raw_q;
  logic               any_pending;

  uart_irq_bus #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .rd_en_i     (rd_en_i),
    .enable_q_i  (enable_q),
    .raw_q_i     (raw_q),
    .enable_we_o (enable_we),
    .clear_we_o  (clear_we),
    .wr_bits_o   (wr_bits),
    .rd_data_o   (rd_data_o)
  );

  uart_irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_set_i   (src_set_i),
    .enable_we_i (enable_we),
    .clear_we_i  (clear_we),
    .wr_bits_i   (wr_bits),
    .enable_q_o  (enable_q),
    .raw_q_o     (raw_q),
    .any_o       (any_pending)
  );

  uart_irq_delay #(.IRQ_DELAY(IRQ_DELAY)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .any_i  (any_pending),
    .irq_o  (irq_o)
  );

  // R6
  irq_needs_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|(raw_q & enable_q)));
endmodule

// File: tb/uart_irq_unit_test.sv
module uart_irq_unit_test;
  localparam int NS = 11;
  localparam int DW = 16;
  localparam int AW = 12;
  localparam int DLY = 3;

  localparam logic [AW-1:0] A_EN  = 12'h038;
  localparam logic [AW-1:0] A_RAW = 12'h03C;
  localparam logic [AW-1:0] A_MSK = 12'h040;
  localparam logic [AW-1:0] A_CLR = 12'h044;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] set_p = '0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          rd = 1'b0;
  logic [DW-1:0] rdata, rdata0;
  logic          irq, irq0;
  int            n_chk = 0;
  int            n_bad = 0;

  always #2 clk = ~clk;

  uart_irq_unit #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW), .IRQ_DELAY(DLY)) uut (
    .clk_i(clk), .rst_ni(rst_n), .src_set_i(set_p), .addr_i(addr), .wr_en_i(wr),
    .wr_data_i(wdata), .rd_en_i(rd), .rd_data_o(rdata), .irq_o(irq));

  uart_irq_unit #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW), .IRQ_DELAY(0)) uut_nodly (
    .clk_i(clk), .rst_ni(rst_n), .src_set_i(set_p), .addr_i(addr), .wr_en_i(wr),
    .wr_data_i(wdata), .rd_en_i(rd), .rd_data_o(rdata0), .irq_o(irq0));

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one cycle of stimulus: drive after negedge, take at posedge, release
  task automatic cyc(input logic [NS-1:0] s, input logic w, input logic [AW-1:0] a,
                     input logic [DW-1:0] d);
    @(negedge clk);
    set_p = s; wr = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    set_p = '0; wr = 1'b0; wdata = '0;
  endtask

  task automatic wreg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc('0, 1'b1, a, d);
  endtask

  task automatic rreg(input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(posedge clk);
    #1;
    rd = 1'b0;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic reset_all();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    reset_all();
    check("R1 irq", {15'd0, irq}, 16'd0);
    rreg(A_EN, v);  check("R1 enable", v, 16'h0000);
    rreg(A_RAW, v); check("R1 raw", v, 16'h0000);
    rreg(A_MSK, v); check("R1 masked", v, 16'h0000);
  endtask

  task automatic t_set_clear();
    logic [DW-1:0] v;
    reset_all();
    cyc(11'h010, 1'b0, A_RAW, '0);
    cyc(11'h401, 1'b0, A_RAW, '0);
    rreg(A_RAW, v); check("R2 raw after sets", v, 16'h0411);
    wreg(A_CLR, 16'h0401);
    rreg(A_RAW, v); check("R3 w1c leaves others", v, 16'h0010);
    rreg(A_CLR, v); check("R3 clear reads zero", v, 16'h0000);
    wreg(A_RAW, 16'h07FF);
    rreg(A_RAW, v); check("R4 raw write ignored", v, 16'h0010);
    rreg(12'h100, v); check("R11 unmapped reads zero", v, 16'h0000);
  endtask

  task automatic t_masked();
    logic [DW-1:0] v;
    reset_all();
    cyc(11'h0F0, 1'b0, A_RAW, '0);
    wreg(A_EN, 16'hFF30);
    rreg(A_EN, v);  check("R10 mask upper bits discarded", v, 16'h0730);
    rreg(A_MSK, v); check("R4 masked = raw & mask", v, 16'h0030);
    wreg(A_MSK, 16'h0000);
    rreg(A_MSK, v); check("R4 masked write ignored", v, 16'h0030);
    wreg(A_CLR, 16'h07FF);
  endtask

  task automatic t_delay();
    int rise = -1;
    reset_all();
    wreg(A_EN, 16'h0010);
    cyc(11'h010, 1'b0, A_RAW, '0);    // masked nonzero from this next cycle (t)
    for (int k = 0; k < DLY + 4; k++) begin
      @(negedge clk);
      if (irq && rise < 0) rise = k;
      @(posedge clk);
    end
    check("R5 irq rise cycle", 16'(rise), 16'(DLY + 1));
    cyc('0, 1'b1, A_CLR, 16'h0010);
    @(negedge clk);
    check("R6 irq drops with masked", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_zero_delay();
    reset_all();
    wreg(A_EN, 16'h0100);
    cyc(11'h100, 1'b0, A_RAW, '0);
    @(negedge clk);
    check("R5 zero delay not yet", {15'd0, irq0}, 16'd0);
    @(negedge clk);
    check("R5 zero delay next cycle", {15'd0, irq0}, 16'd1);
    wreg(A_CLR, 16'h0100);
  endtask

  task automatic t_cancel();
    logic seen = 1'b0;
    reset_all();
    wreg(A_EN, 16'h0020);
    cyc(11'h020, 1'b0, A_RAW, '0);
    cyc('0, 1'b1, A_CLR, 16'h0020);
    for (int k = 0; k < DLY + 6; k++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    check("R7 cancelled never pulses", {15'd0, seen}, 16'd0);
  endtask

  task automatic t_collide();
    logic [DW-1:0] v;
    reset_all();
    wreg(A_EN, 16'h0200);
    cyc(11'h200, 1'b0, A_RAW, '0);
    repeat (DLY + 2) @(negedge clk);
    check("R8 irq up before collision", {15'd0, irq}, 16'd1);
    cyc(11'h200, 1'b1, A_CLR, 16'h0200);
    @(negedge clk);
    check("R8 irq stays after set+clear", {15'd0, irq}, 16'd1);
    rreg(A_RAW, v); check("R8 bit kept", v, 16'h0200);
    wreg(A_CLR, 16'h0200);
  endtask

  task automatic t_remask();
    logic seen = 1'b0;
    logic [DW-1:0] v;
    reset_all();
    cyc(11'h040, 1'b0, A_RAW, '0);
    repeat (DLY + 3) @(negedge clk);
    check("R9 masked-off source keeps irq low", {15'd0, irq}, 16'd0);
    wreg(A_EN, 16'h0040);
    for (int k = 0; k < DLY; k++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    wreg(A_EN, 16'h0000);
    repeat (DLY + 3) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    check("R9 remask inside window no pulse", {15'd0, seen}, 16'd0);
    wreg(A_EN, 16'h0040);
    repeat (DLY + 2) @(negedge clk);
    check("R9 unmask pending asserts", {15'd0, irq}, 16'd1);
    wreg(A_EN, 16'h0000);
    @(negedge clk);
    check("R9 mask all drops irq", {15'd0, irq}, 16'd0);
    rreg(A_RAW, v); check("R9 raw untouched by mask", v, 16'h0040);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_set_clear();
    t_masked();
    t_delay();
    t_zero_delay();
    t_cancel();
    t_collide();
    t_remask();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule